// File: doc/BRIEF.md
# Host-Pulled Capture Word Buffer

This block sits between an input capture datapath and a host processor that only has simple parallel ports. Captured 32-bit words arrive on a valid/ready producer interface and are queued in a FIFO. The host reads them one at a time through a handshake on a single control bit. It raises the bit to take the next word and lowers it once it is done with that word.

A second control bit runs or pauses the whole datapath. While paused, the producer side is refused, but the host can still drain words. The status port shows two conditions: a stall because the buffer is full, and whether any word is waiting. Each status bit drives its own rising-edge capture flag. Each flag can be cleared on its own, and each can raise the interrupt output through a per-bit enable.

Top module: `cap_pull_fifo`

## Requirements
- R1: After reset the FIFO is empty, `in_ready` is 0, and `status`, `cap_flags`, `irq` and `rd_data` are all 0.
- R2: `ctrl[0]` is the run bit. While it is 0, `in_ready` is 0 and no word is accepted. While it is 1 and the FIFO is not full, `in_ready` is 1 and a word offered with `in_valid` is stored.
- R3: `status[0]` is 1 exactly when the FIFO holds DEPTH words. While it is 1, `in_ready` is 0, so no word is lost.
- R4: `ctrl[1]` is the pull bit. It passes through a two-flop synchronizer. A rising edge of the pull bit that is present before clock edge k places the oldest stored word on `rd_data` after clock edge k+2, and removes that word from the FIFO. Words leave in arrival order.
- R5: `rd_data` stays unchanged through the falling edge of the pull bit and until the next rising edge that finds a word.
- R6: A rising edge of the pull bit while the FIFO is empty removes nothing and leaves `rd_data` unchanged.
- R7: Pulls are served while the run bit is 0.
- R8: `status[1]` is 1 while at least one word is stored, and 0 otherwise.
- R9: When bit i of `status` rises, `cap_flags[i]` becomes 1 one clock later and stays 1 until it is cleared.
- R10: A 1 on `cap_clr[i]` at a clock edge clears only `cap_flags[i]`. If the same bit sees a new rising edge in that cycle, the set wins.
- R11: `irq` is 1 exactly when some bit is set in both `cap_flags` and `irq_en`.
- R12: Bits 7..2 of `ctrl` have no effect. Bits 7..2 of `status` and `cap_flags` are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 32 | Producer word |
| in_valid | input | 1 | Producer word valid |
| in_ready | output | 1 | Block accepts a word this cycle |
| ctrl | input | 8 | Bit 0 run, bit 1 pull handshake, others unused |
| status | output | 8 | Bit 0 full stall, bit 1 data available, others 0 |
| cap_flags | output | 8 | Rising-edge capture flags of the status bits |
| cap_clr | input | 8 | Per-bit capture flag clear |
| irq_en | input | 8 | Per-bit interrupt enable |
| irq | output | 1 | Interrupt request |
| rd_data | output | 32 | Word most recently pulled by the host |

## Verification
The bench builds the block with a depth of 4 words instead of 16. With that depth the full stall, its capture flag and refusal at the boundary take only a few pushes to reach. The same run can then be drained to empty and pulled once more. This short depth also lets push-and-pull overlap and pointer wrap around the buffer several times within a short run. The data width and the 8-bit control and status widths stay at their defaults, so the reserved bits are still exercised.

// File: rtl/cap_pull_fifo.sv
module cap_pull_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  parameter int CW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [CW-1:0] ctrl,
  output logic [CW-1:0] status,
  output logic [CW-1:0] cap_flags,
  input  logic [CW-1:0] cap_clr,
  input  logic [CW-1:0] irq_en,
  output logic          irq,
  output logic [DW-1:0] rd_data
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0]   LAST = AW'(DEPTH - 1);
  localparam logic [CNTW-1:0] FULL = CNTW'(DEPTH);

  logic [DW-1:0]   mem [DEPTH];
  logic [AW-1:0]   wr_ptr, rd_ptr;
  logic [CNTW-1:0] count;
  logic [2:0]      pull_sh;
  logic [CW-1:0]   status_q;

  wire full      = (count == FULL);
  wire nonempty  = (count != '0);
  wire pull_rise = pull_sh[1] & ~pull_sh[2];
  wire push      = in_valid & in_ready;
  wire pop       = pull_rise & nonempty;

  assign in_ready = ctrl[0] & ~full;
  assign status   = {{(CW-2){1'b0}}, nonempty, full};
  assign irq      = |(cap_flags & irq_en);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      count     <= '0;
      pull_sh   <= '0;
      rd_data   <= '0;
      status_q  <= '0;
      cap_flags <= '0;
    end else begin
      pull_sh  <= {pull_sh[1:0], ctrl[1]};
      status_q <= status;
      cap_flags <= (cap_flags & ~cap_clr) | (status & ~status_q);
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop) begin
        rd_data <= mem[rd_ptr];
        rd_ptr  <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      end
      count <= count + CNTW'(push) - CNTW'(pop);
    end
  end
endmodule

// File: rtl/cap_pull_fifo_chk.sv
module cap_pull_fifo_chk #(
  parameter int DW = 32,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] ctrl,
  input logic          in_ready,
  input logic [CW-1:0] status,
  input logic [CW-1:0] cap_flags,
  input logic [CW-1:0] cap_clr,
  input logic [DW-1:0] rd_data
);
  a_r2_pause_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[0] |-> !in_ready);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] |-> !in_ready);

  a_r8_full_implies_data: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] |-> status[1]);

  a_r6_data_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> $past(status[1]));

  a_r9_set_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[1]) |=> cap_flags[1]);

  a_r9_sticky0: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_flags[0] && !cap_clr[0]) |=> cap_flags[0]);

  a_r10_clear_one: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_flags[1] && !cap_clr[1] && cap_clr[0]) |=> cap_flags[1]);

  a_r12_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (status[CW-1:2] == '0) && (cap_flags[CW-1:2] == '0));
endmodule

bind cap_pull_fifo cap_pull_fifo_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .in_ready(in_ready),
  .status(status), .cap_flags(cap_flags), .cap_clr(cap_clr), .rd_data(rd_data)
);

// File: tb/cap_pull_fifo_bench.sv
module cap_pull_fifo_bench;
  localparam int DEPTH = 4;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] in_data = 0;
  logic        in_valid = 0;
  logic        in_ready;
  logic [7:0]  ctrl = 0, status, cap_flags, cap_clr = 0, irq_en = 0;
  logic        irq;
  logic [31:0] rd_data;

  always #2.5 clk = ~clk;

  cap_pull_fifo #(.DW(32), .DEPTH(DEPTH), .CW(8)) u_cap_pull_fifo (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .ctrl(ctrl), .status(status), .cap_flags(cap_flags),
    .cap_clr(cap_clr), .irq_en(irq_en), .irq(irq), .rd_data(rd_data)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] q[$];
  logic [31:0] m_rd = 0, nxt_word = 32'hA500_0000, held;
  logic [7:0]  m_cap = 0, m_prev = 0;
  bit ms1 = 0, ms2 = 0, ms3 = 0;

  function automatic logic [7:0] m_stat();
    return {6'b0, q.size() > 0, q.size() == DEPTH};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    bit rise, pop, push;
    logic [7:0] st;
    rise = ms2 && !ms3;
    pop  = rise && q.size() > 0;
    push = in_valid && ctrl[0] && q.size() < DEPTH;
    st   = m_stat();
    m_cap  = (m_cap & ~cap_clr) | (st & ~m_prev);
    m_prev = st;
    ms3 = ms2; ms2 = ms1; ms1 = ctrl[1];
    if (pop) m_rd = q.pop_front();
    if (push) q.push_back(in_data);
    @(posedge clk); #1;
    chk("R2 in_ready", 32'(in_ready), 32'(ctrl[0] && q.size() < DEPTH));
    chk("R3 status[0]", 32'(status[0]), 32'(q.size() == DEPTH));
    chk("R8 status[1]", 32'(status[1]), 32'(q.size() > 0));
    chk("R12 status[7:2]", 32'(status[7:2]), 0);
    chk("R4 rd_data", rd_data, m_rd);
    chk("R9 cap_flags", 32'(cap_flags), 32'(m_cap));
    chk("R11 irq", 32'(irq), 32'(|(m_cap & irq_en)));
  endtask

  task automatic push_n(int n);
    for (int i = 0; i < n; i++) begin
      in_valid = 1; in_data = nxt_word;
      if (ctrl[0] && q.size() < DEPTH) nxt_word++;
      step();
    end
    in_valid = 0;
  endtask

  task automatic pull();
    ctrl[1] = 1; step(); step(); step();
    held = rd_data;
    ctrl[1] = 0; step(); step(); step();
    chk("R5 held after fall", rd_data, held);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 in_ready", 32'(in_ready), 0);
    chk("R1 status", 32'(status), 0);
    chk("R1 cap_flags", 32'(cap_flags), 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 rd_data", rd_data, 0);
    rst_n = 1;
    irq_en = 8'h03;
    // R2: paused, producer refused
    push_n(3);
    chk("R2 paused accepts nothing", 32'(status[1]), 0);
    // run, three words, pull two
    ctrl[0] = 1;
    push_n(3);
    pull();
    chk("R4 first word", rd_data, 32'hA500_0000);
    pull();
    chk("R4 second word", rd_data, 32'hA500_0001);
    // fill past full
    push_n(6);
    chk("R3 full stall", 32'(status[0]), 1);
    // R10: clear full flag only
    cap_clr = 8'h01; step(); cap_clr = 0; step();
    chk("R10 bit1 kept", 32'(cap_flags[1]), 1);
    chk("R10 bit0 cleared", 32'(cap_flags[0]), 0);
    // R12: reserved control bits toggled
    ctrl[7:2] = 6'h3F; step(); step();
    chk("R12 reserved no effect", 32'(status), 32'h3);
    ctrl[7:2] = 0;
    // R7: pause and drain
    ctrl[0] = 0;
    irq_en = 8'h01;
    for (int i = 0; i < DEPTH; i++) pull();
    chk("R7 drained while paused", 32'(status[1]), 0);
    // R6: pull from empty
    held = rd_data;
    pull();
    chk("R6 empty pull", rd_data, held);
    // overlap push and pull
    ctrl[0] = 1; irq_en = 8'hFF; cap_clr = 8'hFF; step(); cap_clr = 0;
    push_n(1);
    ctrl[1] = 1; in_valid = 1; in_data = nxt_word; nxt_word++;
    step(); in_valid = 0; step(); step();
    ctrl[1] = 0; step(); step();
    pull();
    chk("R8 empty at end", 32'(status[1]), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule